// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block is the second stage of a two-level interrupt tree. It watches up to 24 asynchronous event sources, brings each one into the clock domain, and detects rising edges, falling edges or both on it, as a per-source configuration selects. A detected edge is latched as a pending status bit. Two host interrupt lines each have their own status register and their own mask register. Both lines share the one edge-configuration array. Each line drives one active-high summary output, which feeds a primary aggregator.

A host reaches every register through a byte-wide read/write port. A control bit chooses how status is acknowledged. In one mode a read of a status byte clears the bits it returned. In the other mode the host writes ones to the bits it wants cleared. Each status bit also has a one-deep buffer. An event that arrives while its bit is already set is therefore not lost, and it re-raises the bit as soon as the bit is cleared.

Top module: `sih_ctrl`

## Requirements
- R1: Each source passes through two synchronising flops before edge detection. If a source changes before clock edge k, the status bit it causes is set at edge k+2 and is readable from then on.
- R2: Source i has a 2-bit edge field in edge byte i/4 at address 0x10+i/4, at bits [2*(i mod 4)+1 : 2*(i mod 4)]. The upper bit enables rising-edge detection and the lower bit enables falling-edge detection. With both bits set, either edge is detected.
- R3: A source whose edge field is 00 never sets a status bit. Every edge field resets to 00.
- R4: A detected edge sets the source's status bit on both lines, whatever either mask holds.
- R5: Both mask registers reset to all ones. Line output irq_o[l] is high when any status bit of line l has a mask bit of 0 for line l.
- R6: Control register bit 0 at address 0x00 selects clear-on-read and resets to 0. When it is 1, a read of a status byte clears the bits that the read returned, and writes to status bytes have no effect.
- R7: When control bit 0 is 0, writing a 1 to a status bit clears that bit and writing a 0 leaves it unchanged. Reads of status do not clear it.
- R8: An edge on a source whose status bit on a line is already set is held in a one-deep buffer for that line. The first clear of the bit leaves it set, and the second clear empties it.
- R9: If a clear of a status bit and a new edge on that source land in the same cycle, the bit stays set.
- R10: Status, mask and edge bits beyond the implemented sources read as zero and ignore writes. Addresses outside the map read as zero.
- R11: Address map, with b as the byte index: 0x00 control; 0x01+b line-0 status; 0x04+b line-0 mask; 0x07+b line-1 status; 0x0A+b line-1 mask; 0x10+b edge configuration. Read data is valid in the same cycle that the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Asynchronous event sources |
| host_addr | input | 5 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; clear-on-read acts on the clock edge that ends this cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| irq_o | output | 2 | Active-high summary output, one bit per line |

## Verification
The embedded assertions check the per-cycle invariants on every clock. A buffered event must always sit behind a set status bit. A status bit may rise only in the cycle after a detected edge. A cleared bit that has no buffered event and no new edge must fall. A control write must land in the control bit. Other behaviour needs a scenario that the bench stages: the exact latency through the synchroniser, the edge encoding, the shared configuration that feeds two independently acknowledged lines, the two acknowledge modes, and the cycle-exact collision of a clear with a fresh edge. The bench covers these with a behavioural reference model, which it compares against both summary outputs and all read data on every clock.

// File: rtl/sih_pkg.sv
package sih_pkg;
    localparam int MAX_SRC = 24;
    localparam int ADDR_W  = 5;

    // register window bases; the byte index within a window is added on
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_ST0  = 5'h01;
    localparam logic [ADDR_W-1:0] A_MK0  = 5'h04;
    localparam logic [ADDR_W-1:0] A_ST1  = 5'h07;
    localparam logic [ADDR_W-1:0] A_MK1  = 5'h0A;
    localparam logic [ADDR_W-1:0] A_EDGE = 5'h10;

    localparam int N_LINES = 2;
endpackage

// File: rtl/sih_sync.sv
module sih_sync #(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] now_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = src_i;
        sy_d.sync = sy_q.meta;
        sy_d.prev = sy_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign now_o  = sy_q.sync;
    assign prev_o = sy_q.prev;
endmodule

// File: rtl/sih_edge_det.sv
module sih_edge_det #(
    parameter int N = 18
) (
    input  logic [N-1:0]   now_i,
    input  logic [N-1:0]   prev_i,
    input  logic [2*N-1:0] cfg_i,
    output logic [N-1:0]   ev_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic rise_en, fall_en;
        assign rise_en = cfg_i[2*i+1];
        assign fall_en = cfg_i[2*i];
        assign ev_o[i] = (rise_en &  now_i[i] & ~prev_i[i])
                       | (fall_en & ~now_i[i] &  prev_i[i]);
    end
endmodule

// File: rtl/sih_line.sv
module sih_line #(
    parameter int N      = 18,
    parameter int SBYTES = (N + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      ev_i,
    input  logic [N-1:0]      clr_i,
    input  logic [SBYTES-1:0] mask_wr_i,
    input  logic [7:0]        wdata_i,
    output logic [N-1:0]      status_o,
    output logic [N-1:0]      mask_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] pend;
        logic [N-1:0] mask;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        for (int i = 0; i < N; i++) begin
            if (clr_i[i]) begin
                // a buffered event or a fresh edge refills the bit at once
                ln_d.status[i] = ev_i[i] | ln_q.pend[i];
                ln_d.pend[i]   = ev_i[i] & ln_q.pend[i];
            end else begin
                ln_d.status[i] = ln_q.status[i] | ev_i[i];
                ln_d.pend[i]   = ln_q.pend[i] | (ln_q.status[i] & ev_i[i]);
            end
            if (mask_wr_i[i >> 3]) ln_d.mask[i] = wdata_i[i[2:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q.status <= '0;
            ln_q.pend   <= '0;
            ln_q.mask   <= '1;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign status_o = ln_q.status;
    assign mask_o   = ln_q.mask;
    assign irq_o    = |(ln_q.status & ~ln_q.mask);

    // R8
    pend_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.pend & ~ln_q.status) == '0);

    // R1
    rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ln_q.status & ~$past(ln_q.status) & ~$past(ev_i)) == '0));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_i & ~ev_i & ~ln_q.pend) & ln_q.status) == '0));
endmodule

// File: rtl/sih_ctrl.sv
module sih_ctrl
    import sih_pkg::*;
#(
    parameter int N_SRC = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [4:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic [1:0]       irq_o
);
    localparam int SBYTES = (N_SRC + 7) / 8;
    localparam int EBITS  = 2 * N_SRC;
    localparam int EBYTES = (EBITS + 7) / 8;
    localparam int SPAD   = SBYTES * 8;
    localparam int EPAD   = EBYTES * 8;

    typedef struct packed {
        logic             cor;
        logic [EBITS-1:0] edges;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic [N_SRC-1:0]  now_w, prev_w, ev_w;
    logic [N_SRC-1:0]  status_w [N_LINES];
    logic [N_SRC-1:0]  mask_w   [N_LINES];
    logic [N_SRC-1:0]  clr_w    [N_LINES];
    logic [SBYTES-1:0] mkwr_w   [N_LINES];
    logic [SPAD-1:0]   st_pad   [N_LINES];
    logic [SPAD-1:0]   mk_pad   [N_LINES];
    logic [EPAD-1:0]   ed_pad;

    sih_sync #(.N(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .now_o (now_w),
        .prev_o(prev_w)
    );

    sih_edge_det #(.N(N_SRC)) u_edge (
        .now_i (now_w),
        .prev_i(prev_w),
        .cfg_i (ct_q.edges),
        .ev_o  (ev_w)
    );

    // configuration registers: acknowledge mode and the shared edge array
    always_comb begin
        ct_d = ct_q;
        if (host_wr && host_addr == A_CTRL) ct_d.cor = host_wdata[0];
        for (int j = 0; j < EBITS; j++) begin
            if (host_wr && host_addr == A_EDGE + ADDR_W'(j >> 3))
                ct_d.edges[j] = host_wdata[j[2:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        localparam logic [ADDR_W-1:0] ST_BASE = (l == 0) ? A_ST0 : A_ST1;
        localparam logic [ADDR_W-1:0] MK_BASE = (l == 0) ? A_MK0 : A_MK1;

        always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
                clr_w[l][i] = (host_addr == ST_BASE + ADDR_W'(i >> 3)) &
                    ((host_rd &  ct_q.cor & status_w[l][i]) |
                     (host_wr & ~ct_q.cor & host_wdata[i[2:0]]));
            end
            for (int b = 0; b < SBYTES; b++) begin
                mkwr_w[l][b] = host_wr && (host_addr == MK_BASE + ADDR_W'(b));
            end
        end

        sih_line #(.N(N_SRC), .SBYTES(SBYTES)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_w),
            .clr_i    (clr_w[l]),
            .mask_wr_i(mkwr_w[l]),
            .wdata_i  (host_wdata),
            .status_o (status_w[l]),
            .mask_o   (mask_w[l]),
            .irq_o    (irq_o[l])
        );

        assign st_pad[l] = SPAD'(status_w[l]);
        assign mk_pad[l] = SPAD'(mask_w[l]);
    end

    assign ed_pad = EPAD'(ct_q.edges);

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_CTRL) host_rdata[0] = ct_q.cor;
        for (int b = 0; b < SBYTES; b++) begin
            if (host_addr == A_ST0 + ADDR_W'(b)) host_rdata = st_pad[0][b*8 +: 8];
            if (host_addr == A_MK0 + ADDR_W'(b)) host_rdata = mk_pad[0][b*8 +: 8];
            if (host_addr == A_ST1 + ADDR_W'(b)) host_rdata = st_pad[1][b*8 +: 8];
            if (host_addr == A_MK1 + ADDR_W'(b)) host_rdata = mk_pad[1][b*8 +: 8];
        end
        for (int b = 0; b < EBYTES; b++) begin
            if (host_addr == A_EDGE + ADDR_W'(b)) host_rdata = ed_pad[b*8 +: 8];
        end
    end

    // R6
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_CTRL) |=> (ct_q.cor == $past(host_wdata[0])));
endmodule

// File: tb/sih_ctrl_test.sv
`timescale 1ns/1ps
module sih_ctrl_test;
    localparam int N = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [4:0]   addr = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [7:0]   wd = '0;
    logic [7:0]   rdata;
    logic [1:0]   irq;

    int n_chk = 0, n_fail = 0;
    bit mdl_on = 0;
    bit done = 0;

    sih_ctrl #(.N_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .host_addr(addr),
        .host_wr(wr), .host_rd(rd), .host_wdata(wd),
        .host_rdata(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // behavioural reference: delayed source history plus per-line state
    logic [N-1:0]   m_st [2] = '{default: '0};
    logic [N-1:0]   m_pd [2] = '{default: '0};
    logic [N-1:0]   m_mk [2] = '{default: '1};
    logic [2*N-1:0] m_ed = '0;
    bit             m_cor = 0;
    logic [N-1:0]   hist [$] = '{'0, '0, '0};

    function automatic logic [7:0] m_read(input logic [4:0] a);
        logic [39:0] e;
        logic [23:0] s0, s1, k0, k1;
        e = 40'(m_ed); s0 = 24'(m_st[0]); s1 = 24'(m_st[1]);
        k0 = 24'(m_mk[0]); k1 = 24'(m_mk[1]);
        case (a)
            5'h00: return {7'd0, m_cor};
            5'h01, 5'h02, 5'h03: return s0[(a - 5'h01) * 8 +: 8];
            5'h04, 5'h05, 5'h06: return k0[(a - 5'h04) * 8 +: 8];
            5'h07, 5'h08, 5'h09: return s1[(a - 5'h07) * 8 +: 8];
            5'h0A, 5'h0B, 5'h0C: return k1[(a - 5'h0A) * 8 +: 8];
            5'h10, 5'h11, 5'h12, 5'h13, 5'h14: return e[(a - 5'h10) * 8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = '{default: '0}; m_pd = '{default: '0}; m_mk = '{default: '1};
            m_ed = '0; m_cor = 0; hist = '{'0, '0, '0};
        end else begin
            logic [N-1:0] ev;
            logic [N-1:0] older, newer;
            newer = hist[1]; older = hist[2];
            for (int i = 0; i < N; i++)
                ev[i] = (m_ed[2*i+1] & newer[i] & ~older[i]) | (m_ed[2*i] & ~newer[i] & older[i]);
            for (int l = 0; l < 2; l++) begin
                int sbase;
                sbase = (l == 0) ? 1 : 7;
                for (int i = 0; i < N; i++) begin
                    bit hit, c;
                    hit = (int'(addr) == sbase + i / 8);
                    c = hit && ((rd && m_cor && m_st[l][i]) || (wr && !m_cor && wd[i % 8]));
                    if (c) begin
                        m_st[l][i] = ev[i] | m_pd[l][i];
                        m_pd[l][i] = ev[i] & m_pd[l][i];
                    end else begin
                        m_pd[l][i] = m_pd[l][i] | (m_st[l][i] & ev[i]);
                        m_st[l][i] = m_st[l][i] | ev[i];
                    end
                    if (wr && int'(addr) == sbase + 3 + i / 8) m_mk[l][i] = wd[i % 8];
                end
            end
            if (wr && addr == 5'h00) m_cor = wd[0];
            for (int j = 0; j < 2*N; j++)
                if (wr && int'(addr) == 16 + j / 8) m_ed[j] = wd[j % 8];
            void'(hist.pop_back());
            hist.push_front(src);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (mdl_on && rst_n && !done) begin
            logic [1:0] ei;
            ei = {|(m_st[1] & ~m_mk[1]), |(m_st[0] & ~m_mk[0])};
            check(irq == ei, "R5 line output vs model", irq, ei);
            if (rd) check(rdata == m_read(addr), "R11 read data vs model", rdata, m_read(addr));
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic wreg(input logic [4:0] a, input logic [7:0] d);
        addr = a; wd = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rchk(input logic [4:0] a, input logic [7:0] exp, input string req);
        addr = a; rd = 1'b1;
        @(negedge clk);
        check(rdata == exp, req, rdata, exp);
        cyc();
        rd = 1'b0;
    endtask

    task automatic irqchk(input logic [1:0] exp, input string req);
        @(negedge clk);
        check(irq == exp, req, irq, exp);
        cyc();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        mdl_on = 1;
        cyc();
        // reset state
        irqchk(2'b00, "R5 reset outputs low");
        rchk(5'h04, 8'hFF, "R5 mask resets to ones");
        rchk(5'h06, 8'h03, "R10 mask bits above N read zero");
        rchk(5'h10, 8'h00, "R3 edge field resets to 00");
        rchk(5'h00, 8'h00, "R6 clear-on-read off after reset");
        // R3: no edge config, no status
        src[0] = 1'b1; src[5] = 1'b1;
        repeat (4) cyc();
        rchk(5'h01, 8'h00, "R3 edge 00 never pends");
        src[0] = 1'b0;
        repeat (4) cyc();
        // R2 configuration: src0 rising, src5 falling, src17 both
        wreg(5'h10, 8'h02);
        wreg(5'h11, 8'h04);
        wreg(5'h14, 8'h0C);
        rchk(5'h14, 8'h0C, "R2 edge byte readback");
        // R4: edge sets both lines even when masked
        src[0] = 1'b1;
        repeat (4) cyc();
        rchk(5'h01, 8'h01, "R4 line0 status set");
        rchk(5'h07, 8'h01, "R4 line1 status set");
        irqchk(2'b00, "R5 masked lines stay low");
        wreg(5'h0A, 8'hFE);
        irqchk(2'b10, "R5 unmasked line1 asserts");
        // R7 write-one-to-clear on line1 only
        wreg(5'h07, 8'h01);
        rchk(5'h07, 8'h00, "R7 write one clears");
        irqchk(2'b00, "R7 line1 drops after clear");
        rchk(5'h01, 8'h01, "R7 read does not clear, line0 intact");
        // R2 falling edge on src5; src0 falling ignored
        src[5] = 1'b0; src[0] = 1'b0;
        repeat (4) cyc();
        rchk(5'h01, 8'h21, "R2 falling edge detected, rising-only ignores fall");
        // R6 clear-on-read
        wreg(5'h00, 8'h01);
        rchk(5'h00, 8'h01, "R6 control readback");
        rchk(5'h01, 8'h21, "R6 read returns bits");
        rchk(5'h01, 8'h00, "R6 read cleared bits");
        src[0] = 1'b1;
        repeat (4) cyc();
        wreg(5'h01, 8'hFF);
        rchk(5'h01, 8'h01, "R6 status write ignored in clear-on-read");
        // R8 buffered second event on src17 (status byte2 bit1)
        src[17] = 1'b1;
        repeat (4) cyc();
        src[17] = 1'b0;
        repeat (4) cyc();
        rchk(5'h03, 8'h02, "R8 first read");
        rchk(5'h03, 8'h02, "R8 buffered event re-asserts");
        rchk(5'h03, 8'h00, "R8 second clear empties");
        // R9 clear and edge in the same cycle
        wreg(5'h00, 8'h00);
        src[0] = 1'b0;
        repeat (4) cyc();
        wreg(5'h01, 8'h01);
        rchk(5'h01, 8'h00, "R9 precondition status empty");
        src[0] = 1'b1;
        cyc(); cyc();
        wreg(5'h01, 8'h01);
        rchk(5'h01, 8'h01, "R9 colliding clear leaves bit set");
        // R1 latency through the synchroniser
        wreg(5'h01, 8'h01);
        src[0] = 1'b0;
        repeat (4) cyc();
        src[0] = 1'b1;
        cyc(); cyc();
        rchk(5'h01, 8'h00, "R1 not yet set two edges after change");
        rchk(5'h01, 8'h01, "R1 set on third edge after change");
        // R10 unused bits and addresses
        wreg(5'h06, 8'hFF);
        rchk(5'h06, 8'h03, "R10 mask write above N ignored");
        wreg(5'h14, 8'hFF);
        rchk(5'h14, 8'h0F, "R10 edge bits above 2N ignored");
        wreg(5'h1F, 8'hAA);
        rchk(5'h1F, 8'h00, "R10 unmapped address reads zero");
        rchk(5'h03, 8'h00, "R10 status bits above N read zero");
        repeat (4) cyc();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule